// File: doc/BRIEF.md
# Eight-Output Addressable Latch and Line Decoder

This block holds eight single-bit storage cells that share one serial data input. A three-bit select picks the cell to write. Two active-low controls, an enable and a conditional clear, choose between four behaviours: write one cell, hold everything, decode the select onto the outputs, or force every output off. The outputs are inverting and in open-drain style, so a stored logic one shows as a low output, and a high output means "off".

All behaviour is synchronous to a system clock. A transparent-mode change on the data input reaches the selected output one clock later. Releasing enable freezes the value written in the last enabled cycle. The select should stay steady while enable is low. A sticky flag records any cycle that breaks this rule, so firmware or a bench can spot a write that may have landed in the wrong cell.

Top module: `addr_latch_dec`

## Requirements
- R1: With clearN=1 and enableN=0 in a clock cycle, the selected output equals the inverse of dataIn after that rising clock edge.
- R2: In the mode of R1, every output other than the selected one keeps its previous value.
- R3: With clearN=1 and enableN=1, all eight outputs keep their values whatever dataIn and latchSel do.
- R4: With clearN=0 and enableN=0, after the clock edge the selected output equals the inverse of dataIn and the other seven outputs are 1.
- R5: With clearN=0 and enableN=1, after the clock edge all eight outputs are 1 (off).
- R6: latchSel is an unsigned binary number with bit 0 as the least significant bit. Value n selects qOut[n], so 0 selects qOut[0] and 7 selects qOut[7].
- R7: Asserting rstN low, asynchronously, drives qOut to 8'hFF and addrErr to 0.
- R8: When enableN goes from 0 to 1, the value written in the last enabled cycle stays on the selected output.
- R9: When clearN returns high after decoder mode, the outputs keep the values left by decoder mode.
- R10: addrErr goes to 1 one clock after a cycle in which enableN=0 and latchSel differs from its value in the previous cycle. The first cycle after reset is excluded from this comparison. Once set, addrErr stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Serial data bit to store |
| latchSel | input | 3 | Cell select, bit 0 least significant |
| enableN | input | 1 | Active-low write enable |
| clearN | input | 1 | Active-low conditional clear |
| qOut | output | 8 | Inverted cell outputs, 1 = off |
| addrErr | output | 1 | Sticky flag for select change while enabled |

## Verification
In decoder mode, the write to the selected cell and the forced-off of the other seven cells happen in the same clock edge. A select walk runs through all eight values, setting the select while enable is high and then dropping both clear and enable. Each result must be the exact one-cold pattern, which catches an incorrect or missing override. The error flag can also rise in the same cycle as a write. That case is provoked by changing the select while enable is low, and the bench judges both the new flag value and the fact that it stays set through later idle cycles.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } latchMode_e;

  typedef struct packed {
    logic loadSel;     // write inverted data into the selected cell
    logic forceOthers; // drive all non-selected cells off
    logic forceAll;    // drive every cell off
  } latchStrb_t;
endpackage

// File: rtl/alatch_ctrl.sv
module alatch_ctrl
  import alatch_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enableN,
  input  logic             clearN,
  input  logic [SEL_W-1:0] latchSel,
  output latchStrb_t       strb,
  output logic             addrErr
);
  latchMode_e mode;
  logic [SEL_W-1:0] prevSel;
  logic             seenOne;

  always_comb begin
    case ({clearN, enableN})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

  always_comb begin
    strb = '0;
    unique case (mode)
      MODE_WRITE: strb.loadSel = 1'b1;
      MODE_DEMUX: begin
        strb.loadSel     = 1'b1;
        strb.forceOthers = 1'b1;
      end
      MODE_CLEAR: strb.forceAll = 1'b1;
      default:    strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= '0;
      seenOne <= 1'b0;
      addrErr <= 1'b0;
    end else begin
      prevSel <= latchSel;
      seenOne <= 1'b1;
      if (seenOne && !enableN && (latchSel != prevSel))
        addrErr <= 1'b1;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |=> addrErr);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrErr && enableN) |=> !addrErr);
endmodule

// File: rtl/alatch_datapath.sv
module alatch_datapath
  import alatch_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  latchStrb_t          strb,
  input  logic [SEL_W-1:0]    latchSel,
  input  logic                dataIn,
  output logic [(1<<SEL_W)-1:0] qOut
);
  localparam int NUM_OUT = 1 << SEL_W;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    logic hit;
    assign hit = strb.loadSel && (latchSel == SEL_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 qOut[i] <= 1'b1;
      else if (strb.forceAll)    qOut[i] <= 1'b1;
      else if (hit)              qOut[i] <= ~dataIn;
      else if (strb.forceOthers) qOut[i] <= 1'b1;
    end
  end

  // R1
  write_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSel |=> (qOut[$past(latchSel)] == !$past(dataIn)));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(qOut));

  // R4
  demux_cold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceOthers |=> ($countones(qOut) >= NUM_OUT - 1));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceAll |=> (&qOut));
endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec
  import alatch_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dataIn,
  input  logic [SEL_W-1:0]      latchSel,
  input  logic                  enableN,
  input  logic                  clearN,
  output logic [(1<<SEL_W)-1:0] qOut,
  output logic                  addrErr
);
  latchStrb_t strb;

  alatch_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enableN(enableN), .clearN(clearN),
    .latchSel(latchSel), .strb(strb), .addrErr(addrErr)
  );

  alatch_datapath #(.SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .latchSel(latchSel),
    .dataIn(dataIn), .qOut(qOut)
  );
endmodule

// File: tb/addr_latch_dec_tb.sv
module addr_latch_dec_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataIn = 1'b0;
  logic [2:0] latchSel = 3'd0;
  logic       enableN = 1'b1;
  logic       clearN = 1'b1;
  logic [7:0] qOut;
  logic       addrErr;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  addr_latch_dec u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .latchSel(latchSel),
    .enableN(enableN), .clearN(clearN), .qOut(qOut), .addrErr(addrErr)
  );

  // {clearN, enableN, latchSel[2:0], dataIn, expected qOut[7:0]}
  localparam logic [13:0] VEC [13] = '{
    {1'b1, 1'b1, 3'd5, 1'b1, 8'hFF},  // R3 hold
    {1'b1, 1'b0, 3'd5, 1'b1, 8'hDF},  // R1 R2 write cell 5
    {1'b1, 1'b1, 3'd0, 1'b0, 8'hDF},  // R3
    {1'b1, 1'b0, 3'd0, 1'b1, 8'hDE},  // R1 R2 R6 cell 0
    {1'b1, 1'b1, 3'd0, 1'b0, 8'hDE},  // R8 captured value held
    {1'b1, 1'b1, 3'd7, 1'b1, 8'hDE},  // R3
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h5E},  // R1 R6 cell 7
    {1'b1, 1'b0, 3'd7, 1'b0, 8'hDE},  // R1 follows data
    {1'b1, 1'b1, 3'd2, 1'b1, 8'hDE},  // R3
    {1'b0, 1'b0, 3'd2, 1'b1, 8'hFB},  // R4 decoder
    {1'b1, 1'b1, 3'd2, 1'b1, 8'hFB},  // R9 retained
    {1'b0, 1'b1, 3'd4, 1'b1, 8'hFF},  // R5 clear all
    {1'b1, 1'b1, 3'd4, 1'b1, 8'hFF}   // R3
  };

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: qOut actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: addrErr actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic c, logic e, logic [2:0] s, logic d);
    clearN = c; enableN = e; latchSel = s; dataIn = d;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk8("R7", qOut, 8'hFF);
    chk1("R7", addrErr, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 13; k++) begin
      drive(VEC[k][13], VEC[k][12], VEC[k][11:9], VEC[k][8]);
      chk8($sformatf("vector %0d R1..R9", k), qOut, VEC[k][7:0]);
      chk1("R10 no error", addrErr, 1'b0);
    end

    // R6 R4: one-cold decode for every select value
    for (int n = 0; n < 8; n++) begin
      drive(1'b1, 1'b1, 3'(n), 1'b1);
      drive(1'b0, 1'b0, 3'(n), 1'b1);
      chk8($sformatf("R6 decode %0d", n), qOut, ~(8'h01 << n));
    end
    chk1("R10 still clear", addrErr, 1'b0);

    // R4 with data 0: all off
    drive(1'b0, 1'b0, 3'd7, 1'b0);
    chk8("R4 data0", qOut, 8'hFF);

    // R10: select change while enabled
    drive(1'b1, 1'b1, 3'd1, 1'b0);
    drive(1'b1, 1'b0, 3'd1, 1'b0);
    chk1("R10 stable select", addrErr, 1'b0);
    drive(1'b1, 1'b0, 3'd2, 1'b1);
    chk1("R10 set", addrErr, 1'b1);
    drive(1'b1, 1'b1, 3'd2, 1'b0);
    drive(1'b1, 1'b1, 3'd2, 1'b0);
    chk1("R10 sticky", addrErr, 1'b1);

    // R7 asynchronous reset mid-cycle
    #2 rstN = 1'b0;
    #1;
    chk8("R7 async", qOut, 8'hFF);
    chk1("R7 async", addrErr, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule